// File: doc/BRIEF.md
# DDR Bank Command Timing Gate

This block sits beside the command scheduler of a DDR memory controller. It watches every command the scheduler issues and keeps, for each of the four banks, a small set of down-counting timers. Each timer says how many more clocks must pass before one class of command (row open, column read, column write, row close) becomes legal for that bank. A further timer, shared by all banks, spaces row opens to different banks.

All analogue timings are given as parameters in picoseconds, together with the controller clock period. At elaboration they are turned into whole clock counts, always rounding up. Write-with-auto-close recovery is built from the rounded write-recovery count plus the rounded close-to-open count. The scheduler reads the ready outputs and issues only commands whose ready bit is high. The block does not reject illegal commands.

Command codes on `cmd_i`: 0 idle, 1 row open (activate), 2 column read, 3 column write, 4 close one bank (precharge), 5 close all banks. `bank_i` selects the bank for codes 1 to 4. `ap_i` requests an automatic close with codes 2 and 3.

Top module: `ddr_bank_timer`

## Requirements
- R1: Each picosecond timing becomes ceil(t / CLK_PS) clocks. With the default 7500 ps period, open-to-column is 3, close-to-open 3, open-to-close 6, open-to-open 9, cross-bank open spacing 2 and write recovery 2 clocks.
- R2: After a row open (code 1) on bank b, `rd_rdy_o[b]` and `wr_rdy_o[b]` rise exactly open-to-column clocks after the command edge. Neither is ever high while bank b has no open row.
- R3: After a row open on bank b, `pre_rdy_o[b]` rises exactly open-to-close clocks later.
- R4: `act_rdy_o[b]` is low while bank b holds an open row. After bank b is closed, it rises at the later of open-to-open after the last row open and close-to-open after the close.
- R5: After a row open on any bank, `act_gap_ok_o` falls and rises again cross-bank-spacing clocks later. Opens on other banks leave a bank's own column timers untouched.
- R6: A close of bank b (code 4) closes its row and makes `act_rdy_o[b]` wait close-to-open clocks. Close-all (code 5) does the same for every bank, including idle ones.
- R7: After a column write (code 3), the same bank may take another column command 1 clock later. It may take a read only after write latency + burst clocks + 1 clock. It may take a close only after write latency + burst clocks + write recovery. After a column read, a close waits the burst clocks.
- R8: After a write with automatic close, no read or write to that bank is ready. The bank's next row open becomes ready at the latest of: write latency + burst + ceil(tWR) + ceil(tRP) after the write, open-to-open, and open-to-close plus close-to-open.
- R9: After a read with automatic close, the internal close happens at the later of the burst end and open-to-close. The next row open is ready close-to-open clocks after that, and never before open-to-open.
- R10: After reset every bank reads as closed: every `act_rdy_o`, every `pre_rdy_o` and `act_gap_ok_o` are high, and every `rd_rdy_o` and `wr_rdy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Issued command code (0 idle, 1 open, 2 read, 3 write, 4 close, 5 close all) |
| bank_i | input | 2 | Target bank of the command |
| ap_i | input | 1 | Automatic close with a read or write |
| act_rdy_o | output | 4 | Per bank: a row open is legal now |
| rd_rdy_o | output | 4 | Per bank: a column read is legal now |
| wr_rdy_o | output | 4 | Per bank: a column write is legal now |
| pre_rdy_o | output | 4 | Per bank: a close is legal now |
| act_gap_ok_o | output | 1 | Cross-bank row-open spacing met |

## Verification
Each scenario issues one command pattern and then tracks every ready bit, cycle by cycle, until the last one rises. That way an early rise and a late rise are both caught. An open alone separates the column, close and cross-bank spacings. A write followed by a read and a close separates write-to-read from write-to-close and read-to-close. Closes issued early and late tell close-to-open apart from open-to-open. Reads with automatic close at two offsets show whether the burst end or the open-to-close window sets the internal close. A write with automatic close tests the two-term recovery sum.

// File: rtl/ddr_tmg_pkg.sv
package ddr_tmg_pkg;

   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_ACT  = 3'd1,
      CMD_RD   = 3'd2,
      CMD_WR   = 3'd3,
      CMD_PRE  = 3'd4,
      CMD_PREA = 3'd5
   } tcmd_e;

   // round a picosecond span up to whole clocks
   function automatic int unsigned ps_to_ck(input int unsigned t_ps, input int unsigned clk_ps);
      return (t_ps + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tmg_down_cnt.sv
module tmg_down_cnt #(
   parameter int unsigned W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   output logic [W-1:0] cnt_o,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;
   logic [W-1:0] dec;
   logic [W-1:0] nxt;

   always_comb begin
      dec = (cnt_q == '0) ? '0 : cnt_q - W'(1);
      nxt = dec;
      if (ld_i && (ld_val_i > dec)) nxt = ld_val_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= nxt;
   end

   assign cnt_o  = cnt_q;
   assign zero_o = (cnt_q == '0);

   // without a load the count may only fall (rounded counts never grow by themselves)
   p_count_falls_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_i |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/ddr_tmg_bank.sv
module ddr_tmg_bank
   import ddr_tmg_pkg::*;
#(
   parameter int unsigned W        = 5,
   parameter int unsigned RCD_CK   = 3,
   parameter int unsigned RP_CK    = 3,
   parameter int unsigned RAS_CK   = 6,
   parameter int unsigned RC_CK    = 9,
   parameter int unsigned WREC_CK  = 2,
   parameter int unsigned WTR_CK   = 1,
   parameter int unsigned CCD_CK   = 1,
   parameter int unsigned WLAT_CK  = 1,
   parameter int unsigned BURST_CK = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] cmd_i,
   input  logic       sel_i,
   input  logic       ap_i,
   output logic       act_rdy_o,
   output logic       rd_rdy_o,
   output logic       wr_rdy_o,
   output logic       pre_rdy_o
);

   localparam int unsigned WDATA_CK = WLAT_CK + BURST_CK;
   localparam int unsigned DAL_CK   = WREC_CK + RP_CK;

   localparam logic [W-1:0] LD_RC    = W'(RC_CK - 1);
   localparam logic [W-1:0] LD_RCD   = W'(RCD_CK - 1);
   localparam logic [W-1:0] LD_RAS   = W'(RAS_CK - 1);
   localparam logic [W-1:0] LD_RP    = W'(RP_CK - 1);
   localparam logic [W-1:0] LD_CCD   = W'(CCD_CK - 1);
   localparam logic [W-1:0] LD_BURST = W'(BURST_CK - 1);
   localparam logic [W-1:0] LD_W2R   = W'(WDATA_CK + WTR_CK - 1);
   localparam logic [W-1:0] LD_W2P   = W'(WDATA_CK + WREC_CK - 1);
   localparam logic [W-1:0] LD_WAP   = W'(WDATA_CK + DAL_CK - 1);
   localparam logic [W-1:0] RP_W     = W'(RP_CK);

   logic         open_q, open_d;
   logic         act_ld, rd_ld, wr_ld, pre_ld;
   logic [W-1:0] act_val, rd_val, wr_val, pre_val;
   logic [W-1:0] act_cnt, rd_cnt, wr_cnt, pre_cnt;
   logic         act_z, rd_z, wr_z, pre_z;
   logic [W-1:0] pre_dec;
   logic [W-1:0] close_at;

   always_comb begin
      pre_dec  = (pre_cnt == '0) ? '0 : pre_cnt - W'(1);
      close_at = (pre_dec > LD_BURST) ? pre_dec : LD_BURST;
   end

   always_comb begin
      open_d  = open_q;
      act_ld  = 1'b0;  act_val = '0;
      rd_ld   = 1'b0;  rd_val  = '0;
      wr_ld   = 1'b0;  wr_val  = '0;
      pre_ld  = 1'b0;  pre_val = '0;
      if (cmd_i == CMD_PREA) begin
         open_d  = 1'b0;
         act_ld  = 1'b1;
         act_val = LD_RP;
      end else if (sel_i) begin
         case (cmd_i)
            CMD_ACT: begin
               open_d  = 1'b1;
               act_ld  = 1'b1;  act_val = LD_RC;
               rd_ld   = 1'b1;  rd_val  = LD_RCD;
               wr_ld   = 1'b1;  wr_val  = LD_RCD;
               pre_ld  = 1'b1;  pre_val = LD_RAS;
            end
            CMD_RD: begin
               rd_ld   = 1'b1;  rd_val  = LD_CCD;
               wr_ld   = 1'b1;  wr_val  = LD_CCD;
               pre_ld  = 1'b1;  pre_val = LD_BURST;
               if (ap_i) begin
                  open_d  = 1'b0;
                  act_ld  = 1'b1;
                  act_val = close_at + RP_W;
               end
            end
            CMD_WR: begin
               rd_ld   = 1'b1;  rd_val  = LD_W2R;
               wr_ld   = 1'b1;  wr_val  = LD_CCD;
               pre_ld  = 1'b1;  pre_val = LD_W2P;
               if (ap_i) begin
                  open_d  = 1'b0;
                  act_ld  = 1'b1;
                  act_val = ((pre_dec + RP_W) > LD_WAP) ? (pre_dec + RP_W) : LD_WAP;
               end
            end
            CMD_PRE: begin
               open_d  = 1'b0;
               act_ld  = 1'b1;
               act_val = LD_RP;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) open_q <= 1'b0;
      else        open_q <= open_d;
   end

   tmg_down_cnt #(.W(W)) u_act (.clk(clk), .rst_n(rst_n), .ld_i(act_ld), .ld_val_i(act_val),
                                .cnt_o(act_cnt), .zero_o(act_z));
   tmg_down_cnt #(.W(W)) u_rd  (.clk(clk), .rst_n(rst_n), .ld_i(rd_ld),  .ld_val_i(rd_val),
                                .cnt_o(rd_cnt),  .zero_o(rd_z));
   tmg_down_cnt #(.W(W)) u_wr  (.clk(clk), .rst_n(rst_n), .ld_i(wr_ld),  .ld_val_i(wr_val),
                                .cnt_o(wr_cnt),  .zero_o(wr_z));
   tmg_down_cnt #(.W(W)) u_pre (.clk(clk), .rst_n(rst_n), .ld_i(pre_ld), .ld_val_i(pre_val),
                                .cnt_o(pre_cnt), .zero_o(pre_z));

   assign act_rdy_o = act_z && !open_q;
   assign rd_rdy_o  = rd_z && open_q;
   assign wr_rdy_o  = wr_z && open_q;
   assign pre_rdy_o = pre_z;

   logic cmd_act, cmd_close, cmd_wap;
   assign cmd_act   = sel_i && (cmd_i == CMD_ACT);
   assign cmd_close = (sel_i && (cmd_i == CMD_PRE)) || (cmd_i == CMD_PREA);
   assign cmd_wap   = sel_i && (cmd_i == CMD_WR) && ap_i;

   generate
      if (RCD_CK > 1) begin : g_rcd_chk
         p_rcd_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_act |=> (!rd_rdy_o && !wr_rdy_o));
      end
      if (RAS_CK > 1) begin : g_ras_chk
         p_ras_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_act |=> !pre_rdy_o);
      end
   endgenerate

   p_open_blocks_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_act |=> !act_rdy_o);

   p_close_blocks_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_close |=> (!rd_rdy_o && !wr_rdy_o));

   p_wap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wap |=> (!act_rdy_o && !rd_rdy_o && !wr_rdy_o));

endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer
   import ddr_tmg_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned CLK_PS    = 7500,
   parameter int unsigned T_RCD_PS  = 20000,
   parameter int unsigned T_RP_PS   = 20000,
   parameter int unsigned T_RAS_PS  = 45000,
   parameter int unsigned T_RC_PS   = 65000,
   parameter int unsigned T_RRD_PS  = 15000,
   parameter int unsigned T_WR_PS   = 15000,
   parameter int unsigned WTR_CK    = 1,
   parameter int unsigned CCD_CK    = 1,
   parameter int unsigned WLAT_CK   = 1,
   parameter int unsigned BURST_CK  = 2,
   localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           cmd_i,
   input  logic [BANK_W-1:0]    bank_i,
   input  logic                 ap_i,
   output logic [NUM_BANKS-1:0] act_rdy_o,
   output logic [NUM_BANKS-1:0] rd_rdy_o,
   output logic [NUM_BANKS-1:0] wr_rdy_o,
   output logic [NUM_BANKS-1:0] pre_rdy_o,
   output logic                 act_gap_ok_o
);

   localparam int unsigned RCD_CK  = ps_to_ck(T_RCD_PS, CLK_PS);
   localparam int unsigned RP_CK   = ps_to_ck(T_RP_PS,  CLK_PS);
   localparam int unsigned RAS_CK  = ps_to_ck(T_RAS_PS, CLK_PS);
   localparam int unsigned RC_CK   = ps_to_ck(T_RC_PS,  CLK_PS);
   localparam int unsigned RRD_CK  = ps_to_ck(T_RRD_PS, CLK_PS);
   localparam int unsigned WREC_CK = ps_to_ck(T_WR_PS,  CLK_PS);
   localparam int unsigned MAX_CK  = RC_CK + RAS_CK + WLAT_CK + BURST_CK + WREC_CK + RP_CK + WTR_CK;
   localparam int unsigned CNT_W   = $clog2(MAX_CK + 1);

   initial begin
      a_clk_nonzero: assert (CLK_PS > 0) else $error("clock period must be non-zero");
      a_banks_pow2: assert (NUM_BANKS >= 2 && (NUM_BANKS & (NUM_BANKS - 1)) == 0)
         else $error("bank count must be a power of two");
      a_counts_pos: assert (RCD_CK >= 1 && RP_CK >= 1 && RAS_CK >= 1 && RC_CK >= 1 &&
                            RRD_CK >= 1 && CCD_CK >= 1 && BURST_CK >= 1)
         else $error("every spacing must be at least one clock");
   end

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         ddr_tmg_bank #(
            .W(CNT_W), .RCD_CK(RCD_CK), .RP_CK(RP_CK), .RAS_CK(RAS_CK), .RC_CK(RC_CK),
            .WREC_CK(WREC_CK), .WTR_CK(WTR_CK), .CCD_CK(CCD_CK), .WLAT_CK(WLAT_CK),
            .BURST_CK(BURST_CK)
         ) u_bank (
            .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i),
            .sel_i(bank_i == BANK_W'(b)), .ap_i(ap_i),
            .act_rdy_o(act_rdy_o[b]), .rd_rdy_o(rd_rdy_o[b]),
            .wr_rdy_o(wr_rdy_o[b]), .pre_rdy_o(pre_rdy_o[b])
         );
      end
   endgenerate

   logic             any_act;
   logic [CNT_W-1:0] rrd_cnt;
   assign any_act = (cmd_i == CMD_ACT);

   tmg_down_cnt #(.W(CNT_W)) u_rrd (
      .clk(clk), .rst_n(rst_n), .ld_i(any_act), .ld_val_i(CNT_W'(RRD_CK - 1)),
      .cnt_o(rrd_cnt), .zero_o(act_gap_ok_o)
   );

   generate
      if (RRD_CK > 1) begin : g_rrd_chk
         p_rrd_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
            any_act |=> !act_gap_ok_o);
      end
   endgenerate

endmodule

// File: tb/ddr_bank_timer_tb_top.sv
module ddr_bank_timer_tb_top;
   import ddr_tmg_pkg::*;

   localparam int NB    = 4;
   localparam int CKPS  = 7500;
   localparam int NEVER = 1000;
   localparam int DC    = -1;

   function automatic int ck(input int ps);
      return (ps + CKPS - 1) / CKPS;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int RCD = ck(20000);
   localparam int RP  = ck(20000);
   localparam int RAS = ck(45000);
   localparam int RC  = ck(65000);
   localparam int RRD = ck(15000);
   localparam int WRC = ck(15000);
   localparam int WTR = 1, CCD = 1, WLAT = 1, BURST = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    cmd_i = CMD_NOP;
   logic [1:0]    bank_i = '0;
   logic          ap_i = 1'b0;
   logic [NB-1:0] act_rdy, rd_rdy, wr_rdy, pre_rdy;
   logic          act_gap_ok;

   always #5 clk = ~clk;

   ddr_bank_timer dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .ap_i(ap_i),
      .act_rdy_o(act_rdy), .rd_rdy_o(rd_rdy), .wr_rdy_o(wr_rdy), .pre_rdy_o(pre_rdy),
      .act_gap_ok_o(act_gap_ok)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input string what, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
      end
   endtask

   function automatic logic due(input int n, input int k);
      return (k + 1 >= n);
   endfunction

   // k = clocks since the command edge minus one; n = edge distance at which a command becomes legal
   task automatic watch(input string req, input int b, input int na, input int nr, input int nw,
                        input int np, input int ng, input int span);
      for (int k = 0; k < span; k++) begin
         if (k > 0) @(negedge clk);
         if (na != DC) chk(req, $sformatf("act_rdy[%0d] k=%0d", b, k), act_rdy[b], due(na, k));
         if (nr != DC) chk(req, $sformatf("rd_rdy[%0d] k=%0d", b, k), rd_rdy[b], due(nr, k));
         if (nw != DC) chk(req, $sformatf("wr_rdy[%0d] k=%0d", b, k), wr_rdy[b], due(nw, k));
         if (np != DC) chk(req, $sformatf("pre_rdy[%0d] k=%0d", b, k), pre_rdy[b], due(np, k));
         if (ng != DC) chk(req, $sformatf("act_gap_ok k=%0d", k), act_gap_ok, due(ng, k));
      end
   endtask

   task automatic issue(input logic [2:0] c, input int b, input logic ap);
      cmd_i = c; bank_i = 2'(b); ap_i = ap;
      @(negedge clk);
      cmd_i = CMD_NOP; ap_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cmd_i = CMD_NOP; ap_i = 1'b0;
      idle(2);
      rst_n = 1'b1;
   endtask

   // R10: every bank idle after reset
   task automatic t_reset();
      do_reset();
      for (int b = 0; b < NB; b++) begin
         chk("R10", $sformatf("act_rdy[%0d]", b), act_rdy[b], 1'b1);
         chk("R10", $sformatf("rd_rdy[%0d]", b), rd_rdy[b], 1'b0);
         chk("R10", $sformatf("wr_rdy[%0d]", b), wr_rdy[b], 1'b0);
         chk("R10", $sformatf("pre_rdy[%0d]", b), pre_rdy[b], 1'b1);
      end
      chk("R10", "act_gap_ok", act_gap_ok, 1'b1);
   endtask

   // R1 R2 R3 R4 R5: a lone row open
   task automatic t_open();
      do_reset();
      issue(CMD_ACT, 0, 1'b0);
      chk("R5", "act_rdy[1] other bank", act_rdy[1], 1'b1);
      watch("R1/R2/R3/R4/R5", 0, NEVER, RCD, RCD, RAS, RRD, RC + 1);
   endtask

   // R5: second open on another bank at the earliest spacing
   task automatic t_cross_bank();
      do_reset();
      issue(CMD_ACT, 0, 1'b0);
      idle(RRD - 1);
      chk("R5", "act_gap_ok before 2nd open", act_gap_ok, 1'b1);
      issue(CMD_ACT, 1, 1'b0);
      chk("R5", "rd_rdy[0] untouched", rd_rdy[0], (RRD + 1 >= RCD) ? 1'b1 : 1'b0);
      watch("R5", 1, NEVER, RCD, RCD, RAS, RRD, RAS);
   endtask

   // R7 R6: write, read, close on one bank
   task automatic t_write_read_close();
      do_reset();
      issue(CMD_ACT, 0, 1'b0);
      idle(RCD - 1);
      issue(CMD_WR, 0, 1'b0);
      watch("R7", 0, NEVER, WLAT + BURST + WTR, CCD,
            mx(RAS - RCD, WLAT + BURST + WRC), 1, WLAT + BURST + WRC + 1);
      issue(CMD_RD, 0, 1'b0);
      watch("R7", 0, NEVER, CCD, CCD, BURST, DC, BURST + 1);
      issue(CMD_PRE, 0, 1'b0);
      watch("R6", 0, RP, NEVER, NEVER, 1, DC, RP + 1);
   endtask

   // R4: close at the earliest point, reopen bounded by open-to-open
   task automatic t_close_early();
      do_reset();
      issue(CMD_ACT, 2, 1'b0);
      idle(RAS - 1);
      issue(CMD_PRE, 2, 1'b0);
      watch("R4", 2, mx(RP, RC - RAS), NEVER, NEVER, DC, DC, mx(RP, RC - RAS) + 1);
   endtask

   // R6: close-all one clock late; every bank waits close-to-open
   task automatic t_close_all();
      int off;
      off = RAS + 1;
      do_reset();
      issue(CMD_ACT, 3, 1'b0);
      idle(off - 1);
      issue(CMD_PREA, 0, 1'b0);
      for (int k = 0; k <= RP; k++) begin
         if (k > 0) @(negedge clk);
         for (int b = 0; b < NB; b++) begin
            int n;
            n = (b == 3) ? mx(RP, RC - off) : RP;
            chk("R6", $sformatf("act_rdy[%0d] k=%0d", b, k), act_rdy[b], due(n, k));
            chk("R6", $sformatf("wr_rdy[%0d] k=%0d", b, k), wr_rdy[b], 1'b0);
         end
      end
   endtask

   // R8: write with automatic close
   task automatic t_write_auto();
      int off, n;
      off = RCD;
      n = mx(mx(RC - off, WLAT + BURST + WRC + RP), mx(RAS - off, 0) + RP);
      do_reset();
      issue(CMD_ACT, 2, 1'b0);
      idle(off - 1);
      issue(CMD_WR, 2, 1'b1);
      watch("R8", 2, n, NEVER, NEVER, DC, DC, n + 1);
   endtask

   // R9: read with automatic close at a given offset from the open
   task automatic t_read_auto(input int off);
      int n;
      n = mx(mx(BURST + RP, mx(RAS - off, 0) + RP), RC - off);
      do_reset();
      issue(CMD_ACT, 1, 1'b0);
      idle(off - 1);
      issue(CMD_RD, 1, 1'b1);
      watch("R9", 1, n, NEVER, NEVER, DC, DC, n + 1);
   endtask

   initial begin
      idle(1);
      t_reset();
      t_open();
      t_cross_bank();
      t_write_read_close();
      t_close_early();
      t_close_all();
      t_write_auto();
      t_read_auto(RCD);
      t_read_auto(RAS - 1);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule